// File: doc/BRIEF.md
# Forward-Error-Correction Symbol Error Injector

This block sits in the transmit path of a Reed-Solomon coded stream of 10-bit symbols, after the encoder. A start-of-codeword flag marks the first symbol of each codeword. While the block is armed or running, it corrupts selected symbols of selected codewords by XOR with a bit pattern. Every symbol leaves the block one clock after it enters. The block also keeps running totals of what it sent.

Injection is organised in cycles, each a programmed, even number of codewords long. The leading codewords of each cycle carry errors and the rest are clean. Inside an errored codeword, the symbol positions taken from a short programmed list are corrupted. The pattern is one of three: the programmed mask, the mask rotated once per errored symbol, or an upward count. A loop mode sets how many cycles run: one, a programmed number, or an open-ended run that a stop request ends at the next codeword boundary.

Top module: `fec_err_injector`

## Requirements
- R1: Every input symbol appears on the output exactly one clock later, with its valid and start-of-codeword flags. A symbol that is not selected for injection leaves unchanged.
- R2: A start pulse while idle arms the block and raises busy. The run begins at the next start-of-codeword. A start with an odd or zero codewords-per-cycle value is rejected: busy stays low and no symbol is altered.
- R3: Number the codewords of a run from k = 0. Codeword k is in the errored phase when k modulo codewords-per-cycle is below the errored-codeword count.
- R4: Symbol positions count from 0 at the start-of-codeword symbol. In an errored-phase codeword, only positions equal to one of the first `cfg_idx_cnt` list entries are corrupted. List entry j occupies bits [j*W +: W] of the list port, where W = log2(symbols per codeword).
- R5: Pattern mode 0 (static): every corrupted symbol is XORed with the mask.
- R6: Pattern mode 1 (rotate): the n-th corrupted symbol of a run (n from 0) is XORed with the mask rotated left by n mod 10 places. Bit 9 wraps into bit 0.
- R7: Pattern mode 2 (increment): the mask is ignored. The n-th corrupted symbol of a run is XORed with (n mod 511) + 1, so the pattern goes 1, 2, ... 511 and then back to 1.
- R8: Loop mode 0 (single) ends the run after one cycle. Mode 2 (repeat) ends it after the programmed number of cycles, and a count of 0 acts as 1. Mode 1 (continuous) runs until stopped. A run ends at the first start-of-codeword after its last codeword. That codeword is sent clean, and busy falls one clock later.
- R9: A stop pulse during a run ends the run at the next start-of-codeword, and that codeword and all later ones are sent clean. A stop pulse while armed returns the block to idle.
- R10: The counters total the codewords sent and the corrupted symbols. They also sort each codeword into one of three classes. A codeword is correctable when it is in the errored phase, has a nonzero list count, and that count is at most CORR_LIMIT. It is uncorrectable when it meets the first two conditions and the count exceeds CORR_LIMIT. Every other codeword is error-free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input symbol valid |
| in_sof | input | 1 | Input symbol is the first of a codeword |
| in_sym | input | 10 | Input symbol |
| start | input | 1 | Arm request pulse |
| stop | input | 1 | Stop request pulse |
| cfg_cw_per_cycle | input | 16 | Codewords per injection cycle (even, nonzero) |
| cfg_err_cws | input | 16 | Leading errored codewords per cycle |
| cfg_idx_list | input | MAX_ERR*W | Packed errored symbol positions |
| cfg_idx_cnt | input | clog2(MAX_ERR+1) | Number of list entries in use |
| cfg_mask | input | 10 | Bit error mask |
| cfg_pat_mode | input | 2 | 0 static, 1 rotate, 2 increment |
| cfg_loop_mode | input | 2 | 0 single, 1 continuous, 2 repeat |
| cfg_repeat | input | 16 | Cycle count for repeat mode |
| out_valid | output | 1 | Output symbol valid |
| out_sof | output | 1 | Output start-of-codeword |
| out_sym | output | 10 | Output symbol |
| busy | output | 1 | Armed or running |
| cnt_tx_cw | output | CNT_W | Codewords sent |
| cnt_corr_cw | output | CNT_W | Correctable codewords |
| cnt_uncorr_cw | output | CNT_W | Uncorrectable codewords |
| cnt_clean_cw | output | CNT_W | Error-free codewords |
| cnt_err_sym | output | CNT_W | Corrupted symbols |

## Verification
The assertions take three things about the inputs as given. Codewords arrive whole: a start-of-codeword after exactly the configured number of valid symbols. Configuration stays constant while busy is high. List entries are distinct and lie inside the codeword. The bench drives only complete eight-symbol codewords, and it changes configuration only between runs, while busy is low. It draws its list entries from distinct positions below eight, so every property's premises hold throughout the run.

// File: rtl/fec_inj_pkg.sv
package fec_inj_pkg;
  localparam int SYM_W = 10;
  localparam int CFG_W = 16;
  localparam logic [SYM_W-1:0] INC_TOP = {1'b0, {(SYM_W-1){1'b1}}};

  typedef enum logic [1:0] {PAT_STATIC = 2'd0, PAT_ROTATE = 2'd1, PAT_INCR = 2'd2} pat_mode_e;
  typedef enum logic [1:0] {LOOP_SINGLE = 2'd0, LOOP_CONT = 2'd1, LOOP_REPEAT = 2'd2} loop_mode_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_RUN} run_state_e;

  // one place toward the MSB, top bit wraps to bit 0
  function automatic logic [SYM_W-1:0] rot_left1(input logic [SYM_W-1:0] v);
    return {v[SYM_W-2:0], v[SYM_W-1]};
  endfunction

  // upward count 1..INC_TOP, then back to 1
  function automatic logic [SYM_W-1:0] incr_next(input logic [SYM_W-1:0] v);
    return (v == INC_TOP) ? {{(SYM_W-1){1'b0}}, 1'b1} : v + 1'b1;
  endfunction

  function automatic logic cpc_ok(input logic [CFG_W-1:0] c);
    return (c != '0) && !c[0];
  endfunction
endpackage

// File: rtl/fec_cycle_ctrl.sv
module fec_cycle_ctrl
  import fec_inj_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             sof_evt,
  input  logic [CFG_W-1:0] cfg_cpc,
  input  logic [CFG_W-1:0] cfg_ncw,
  input  logic [1:0]       cfg_loop,
  input  logic [CFG_W-1:0] cfg_rep,
  output logic             busy,
  output logic             run_begin,
  output logic             cw_err_now
);
  run_state_e       state;
  logic [CFG_W-1:0] cw_idx, nxt_idx;
  logic [CFG_W-1:0] cyc_cnt;
  logic [CFG_W:0]   cyc_nxt, rep_lim;
  logic             stop_pend, cw_err_q;
  logic             last_cw, cycle_done, finish, start_reject, start_accept;

  assign last_cw      = (cw_idx == cfg_cpc - 1'b1);
  assign cyc_nxt      = {1'b0, cyc_cnt} + 1'b1;
  assign rep_lim      = (cfg_rep == '0) ? {{CFG_W{1'b0}}, 1'b1} : {1'b0, cfg_rep};
  assign cycle_done   = last_cw && ((cfg_loop == LOOP_SINGLE) ||
                                    ((cfg_loop == LOOP_REPEAT) && (cyc_nxt >= rep_lim)));
  assign finish       = (state == ST_RUN) && sof_evt && (stop_pend || stop || cycle_done);
  assign nxt_idx      = last_cw ? '0 : cw_idx + 1'b1;
  assign run_begin    = (state == ST_ARMED) && sof_evt && !stop;
  assign start_accept = (state == ST_IDLE) && start && cpc_ok(cfg_cpc);
  assign start_reject = (state == ST_IDLE) && start && !cpc_ok(cfg_cpc);
  assign busy         = (state != ST_IDLE);

  always_comb begin
    cw_err_now = cw_err_q;
    if (sof_evt) begin
      if (run_begin)                       cw_err_now = (cfg_ncw != '0);
      else if (state == ST_RUN && !finish) cw_err_now = (nxt_idx < cfg_ncw);
      else                                 cw_err_now = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cw_idx    <= '0;
      cyc_cnt   <= '0;
      stop_pend <= 1'b0;
      cw_err_q  <= 1'b0;
    end else begin
      if (sof_evt) cw_err_q <= cw_err_now;
      unique case (state)
        ST_IDLE: begin
          stop_pend <= 1'b0;
          if (start_accept) state <= ST_ARMED;
        end
        ST_ARMED: begin
          if (stop) state <= ST_IDLE;
          else if (sof_evt) begin
            state   <= ST_RUN;
            cw_idx  <= '0;
            cyc_cnt <= '0;
          end
        end
        ST_RUN: begin
          if (stop) stop_pend <= 1'b1;
          if (finish) begin
            state     <= ST_IDLE;
            stop_pend <= 1'b0;
          end else if (sof_evt) begin
            cw_idx <= nxt_idx;
            if (last_cw) cyc_cnt <= cyc_nxt[CFG_W-1:0];
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: rejected start leaves the block idle
  p_reject_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |=> !busy);
  // R9: pending stop closes the run at the boundary
  p_stop_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && sof_evt && stop_pend) |=> !busy && !cw_err_q);
  // R3: codeword index stays inside the cycle
  p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (cw_idx < cfg_cpc));
  // R8: single mode never completes a cycle while running
  p_single_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && cfg_loop == LOOP_SINGLE) |-> (cyc_cnt == '0));
endmodule

// File: rtl/fec_sym_match.sv
module fec_sym_match #(
  parameter int MAX_ERR = 16,
  parameter int POS_W   = 10,
  parameter int NCNT_W  = 5
) (
  input  logic [MAX_ERR*POS_W-1:0] idx_list,
  input  logic [NCNT_W-1:0]        idx_cnt,
  input  logic [POS_W-1:0]         pos,
  output logic                     match
);
  logic [MAX_ERR-1:0] hit_vec;

  for (genvar j = 0; j < MAX_ERR; j++) begin : g_ent
    assign hit_vec[j] = (idx_cnt > NCNT_W'(j)) && (idx_list[j*POS_W +: POS_W] == pos);
  end

  assign match = |hit_vec;
endmodule

// File: rtl/fec_pattern_gen.sv
module fec_pattern_gen
  import fec_inj_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [1:0]       mode,
  input  logic [SYM_W-1:0] mask,
  output logic [SYM_W-1:0] pat
);
  logic [SYM_W-1:0] rot_q, inc_q, rot_base, inc_base;

  assign rot_base = load ? mask : rot_q;
  assign inc_base = load ? {{(SYM_W-1){1'b0}}, 1'b1} : inc_q;

  always_comb begin
    unique case (mode)
      PAT_ROTATE: pat = rot_base;
      PAT_INCR:   pat = inc_base;
      default:    pat = mask;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rot_q <= '0;
      inc_q <= {{(SYM_W-1){1'b0}}, 1'b1};
    end else if (load || adv) begin
      rot_q <= adv ? rot_left1(rot_base) : rot_base;
      inc_q <= adv ? incr_next(inc_base) : inc_base;
    end
  end

  // R7: increment pattern is never zero and never sets the top bit
  p_incr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PAT_INCR && load) |-> (pat != '0) && !pat[SYM_W-1]);
  // R6: rotate pattern advances one place per corrupted symbol
  p_rotate_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode == PAT_ROTATE) |=> (load || mode != PAT_ROTATE || pat == rot_left1($past(pat))));
  // R7: increment pattern steps by one with wrap
  p_incr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode == PAT_INCR) |=> (load || mode != PAT_INCR || pat == incr_next($past(pat))));
endmodule

// File: rtl/fec_inj_counters.sv
module fec_inj_counters #(
  parameter int CNT_W      = 32,
  parameter int NCNT_W     = 5,
  parameter int CORR_LIMIT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_evt,
  input  logic              cw_err,
  input  logic [NCNT_W-1:0] idx_cnt,
  input  logic              sym_hit,
  output logic [CNT_W-1:0]  cnt_tx,
  output logic [CNT_W-1:0]  cnt_corr,
  output logic [CNT_W-1:0]  cnt_uncorr,
  output logic [CNT_W-1:0]  cnt_clean,
  output logic [CNT_W-1:0]  cnt_sym
);
  logic errored, over, ev_corr, ev_uncorr, ev_clean;

  assign errored   = cw_err && (idx_cnt != '0);
  assign over      = int'(idx_cnt) > CORR_LIMIT;
  assign ev_corr   = sof_evt && errored && !over;
  assign ev_uncorr = sof_evt && errored && over;
  assign ev_clean  = sof_evt && !errored;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_tx     <= '0;
      cnt_corr   <= '0;
      cnt_uncorr <= '0;
      cnt_clean  <= '0;
      cnt_sym    <= '0;
    end else begin
      if (sof_evt)   cnt_tx     <= cnt_tx + 1'b1;
      if (ev_corr)   cnt_corr   <= cnt_corr + 1'b1;
      if (ev_uncorr) cnt_uncorr <= cnt_uncorr + 1'b1;
      if (ev_clean)  cnt_clean  <= cnt_clean + 1'b1;
      if (sym_hit)   cnt_sym    <= cnt_sym + 1'b1;
    end
  end

  // R10: each codeword lands in exactly one class
  p_class_sum_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_tx == cnt_corr + cnt_uncorr + cnt_clean));
  p_class_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sof_evt |-> $onehot({ev_corr, ev_uncorr, ev_clean}));
endmodule

// File: rtl/fec_err_injector.sv
module fec_err_injector
  import fec_inj_pkg::*;
#(
  parameter  int CW_SYMS    = 544,
  parameter  int MAX_ERR    = 16,
  parameter  int CORR_LIMIT = 15,
  parameter  int CNT_W      = 32,
  localparam int POS_W      = $clog2(CW_SYMS),
  localparam int NCNT_W     = $clog2(MAX_ERR + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_sof,
  input  logic [SYM_W-1:0]         in_sym,
  input  logic                     start,
  input  logic                     stop,
  input  logic [CFG_W-1:0]         cfg_cw_per_cycle,
  input  logic [CFG_W-1:0]         cfg_err_cws,
  input  logic [MAX_ERR*POS_W-1:0] cfg_idx_list,
  input  logic [NCNT_W-1:0]        cfg_idx_cnt,
  input  logic [SYM_W-1:0]         cfg_mask,
  input  logic [1:0]               cfg_pat_mode,
  input  logic [1:0]               cfg_loop_mode,
  input  logic [CFG_W-1:0]         cfg_repeat,
  output logic                     out_valid,
  output logic                     out_sof,
  output logic [SYM_W-1:0]         out_sym,
  output logic                     busy,
  output logic [CNT_W-1:0]         cnt_tx_cw,
  output logic [CNT_W-1:0]         cnt_corr_cw,
  output logic [CNT_W-1:0]         cnt_uncorr_cw,
  output logic [CNT_W-1:0]         cnt_clean_cw,
  output logic [CNT_W-1:0]         cnt_err_sym
);
  logic             sof_evt, run_begin, cw_err_now, pos_match, sym_hit;
  logic [POS_W-1:0] pos_q, pos_cur;
  logic [SYM_W-1:0] pat;

  assign sof_evt = in_valid && in_sof;
  assign pos_cur = in_sof ? '0 : pos_q + 1'b1;
  assign sym_hit = in_valid && cw_err_now && pos_match;

  fec_cycle_ctrl i_ctrl (
    .clk, .rst_n, .start, .stop, .sof_evt,
    .cfg_cpc(cfg_cw_per_cycle), .cfg_ncw(cfg_err_cws),
    .cfg_loop(cfg_loop_mode), .cfg_rep(cfg_repeat),
    .busy, .run_begin, .cw_err_now
  );

  fec_sym_match #(.MAX_ERR(MAX_ERR), .POS_W(POS_W), .NCNT_W(NCNT_W)) i_match (
    .idx_list(cfg_idx_list), .idx_cnt(cfg_idx_cnt), .pos(pos_cur), .match(pos_match)
  );

  fec_pattern_gen i_pat (
    .clk, .rst_n, .load(run_begin), .adv(sym_hit),
    .mode(cfg_pat_mode), .mask(cfg_mask), .pat
  );

  fec_inj_counters #(.CNT_W(CNT_W), .NCNT_W(NCNT_W), .CORR_LIMIT(CORR_LIMIT)) i_cnt (
    .clk, .rst_n, .sof_evt, .cw_err(cw_err_now), .idx_cnt(cfg_idx_cnt), .sym_hit,
    .cnt_tx(cnt_tx_cw), .cnt_corr(cnt_corr_cw), .cnt_uncorr(cnt_uncorr_cw),
    .cnt_clean(cnt_clean_cw), .cnt_sym(cnt_err_sym)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q     <= '0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_sym   <= '0;
    end else begin
      if (in_valid) pos_q <= pos_cur;
      out_valid <= in_valid;
      out_sof   <= sof_evt;
      out_sym   <= sym_hit ? (in_sym ^ pat) : in_sym;
    end
  end

  // R1: fixed one-clock latency of the valid flag
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_no_ghost_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R4: unselected symbols pass untouched
  p_passthru_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sym_hit) |=> (out_sym == $past(in_sym)));
  // R2: nothing is corrupted while idle
  p_idle_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sym_hit);
endmodule

// File: tb/test_fec_err_injector.sv
module test_fec_err_injector;
  localparam int CWS = 8;
  localparam int ME  = 4;
  localparam int LIM = 2;
  localparam int PW  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sof = 0, start = 0, stop = 0;
  logic [9:0] in_sym = '0, cfg_mask = '0;
  logic [15:0] cfg_cpc = '0, cfg_ncw = '0, cfg_rep = '0;
  logic [ME*PW-1:0] cfg_list = '0;
  logic [2:0] cfg_cnt = '0;
  logic [1:0] cfg_pat = '0, cfg_loop = '0;
  logic out_valid, out_sof, busy;
  logic [9:0] out_sym;
  logic [15:0] c_tx, c_corr, c_unc, c_clean, c_sym;

  int total = 0, bad = 0;
  int e_tx = 0, e_corr = 0, e_unc = 0, e_clean = 0, e_sym = 0;
  int lst[ME];
  int n_err;

  always #2 clk = ~clk;

  fec_err_injector #(.CW_SYMS(CWS), .MAX_ERR(ME), .CORR_LIMIT(LIM), .CNT_W(16)) i_fec_err_injector (
    .clk, .rst_n, .in_valid, .in_sof, .in_sym, .start, .stop,
    .cfg_cw_per_cycle(cfg_cpc), .cfg_err_cws(cfg_ncw), .cfg_idx_list(cfg_list),
    .cfg_idx_cnt(cfg_cnt), .cfg_mask(cfg_mask), .cfg_pat_mode(cfg_pat),
    .cfg_loop_mode(cfg_loop), .cfg_repeat(cfg_rep),
    .out_valid, .out_sof, .out_sym, .busy,
    .cnt_tx_cw(c_tx), .cnt_corr_cw(c_corr), .cnt_uncorr_cw(c_unc),
    .cnt_clean_cw(c_clean), .cnt_err_sym(c_sym)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pattern(input int n);
    int s, m;
    m = int'(cfg_mask);
    s = n % 10;
    if (cfg_pat == 2'd1) return ((m << s) | (m >> (10 - s))) & 1023;
    if (cfg_pat == 2'd2) return (n % 511) + 1;
    return m;
  endfunction

  task automatic set_list(input int a, input int b, input int c, input int d, input int n);
    lst[0] = a; lst[1] = b; lst[2] = c; lst[3] = d;
    for (int j = 0; j < ME; j++) cfg_list[j*PW +: PW] = PW'(lst[j]);
    cfg_cnt = 3'(n);
  endtask

  task automatic pulse(input bit is_start);
    @(negedge clk);
    in_valid = 0; start = is_start; stop = !is_start;
    @(negedge clk);
    start = 0; stop = 0;
  endtask

  // active: number of run codewords that may carry errors (-1 = unbounded)
  // stop_k: stop pulse issued inside codeword stop_k-1 (-1 = none)
  task automatic run_cws(input int ncws, input int active, input int stop_k, input string req);
    for (int k = 0; k < ncws; k++) begin
      bit in_run, errcw;
      in_run = (active < 0 || k < active) && (stop_k < 0 || k < stop_k);
      errcw  = in_run && ((k % int'(cfg_cpc)) < int'(cfg_ncw)) && (cfg_cnt != 0);
      e_tx++;
      if (errcw && int'(cfg_cnt) > LIM) e_unc++;
      else if (errcw) e_corr++;
      else e_clean++;
      for (int p = 0; p < CWS; p++) begin
        bit hit;
        int sv, ev;
        hit = 0;
        for (int j = 0; j < ME; j++) if (errcw && j < int'(cfg_cnt) && lst[j] == p) hit = 1;
        sv = (k * 53 + p * 29 + 7) & 1023;
        ev = hit ? (sv ^ pattern(n_err)) : sv;
        if (hit) begin n_err++; e_sym++; end
        @(negedge clk);
        in_valid = 1; in_sof = (p == 0); in_sym = 10'(sv);
        stop = (stop_k >= 1 && k == stop_k - 1 && p == 3);
        @(posedge clk); #1;
        chk({req, " R1 valid"}, int'(out_valid), 1);
        chk({req, " R1 sof"}, int'(out_sof), int'(p == 0));
        chk({req, " R3/R4 symbol"}, int'(out_sym), ev);
      end
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; stop = 0;
    @(negedge clk);
  endtask

  task automatic chk_counters(input string req);
    chk({req, " R10 tx"}, int'(c_tx), e_tx);
    chk({req, " R10 corr"}, int'(c_corr), e_corr);
    chk({req, " R10 uncorr"}, int'(c_unc), e_unc);
    chk({req, " R10 clean"}, int'(c_clean), e_clean);
    chk({req, " R10 symbols"}, int'(c_sym), e_sym);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset out_valid", int'(out_valid), 0);
    chk("R2 reset busy", int'(busy), 0);
    chk_counters("reset");

    // R5 static, single mode (R8), correctable class
    cfg_cpc = 4; cfg_ncw = 2; cfg_loop = 0; cfg_pat = 0; cfg_mask = 10'h201;
    set_list(1, 5, 0, 0, 2);
    n_err = 0;
    pulse(1);
    chk("R2 armed busy", int'(busy), 1);
    run_cws(6, 4, -1, "R5 static");
    chk("R8 single ends", int'(busy), 0);
    chk_counters("R5");

    // R6 rotate, repeat mode, uncorrectable class
    cfg_cpc = 2; cfg_ncw = 1; cfg_loop = 2; cfg_rep = 2; cfg_pat = 1; cfg_mask = 10'h203;
    set_list(0, 3, 7, 0, 3);
    n_err = 0;
    pulse(1);
    run_cws(5, 4, -1, "R6 rotate");
    chk("R8 repeat ends", int'(busy), 0);
    chk_counters("R6");

    // R7 increment with wrap, continuous mode ended by stop (R9)
    cfg_cpc = 2; cfg_ncw = 2; cfg_loop = 1; cfg_pat = 2; cfg_mask = 10'h3FF;
    set_list(0, 2, 4, 7, 2);
    set_list(0, 1, 2, 3, 4);
    n_err = 0;
    pulse(1);
    run_cws(131, -1, 130, "R7 incr");
    chk("R9 continuous stopped", int'(busy), 0);
    chk_counters("R7");

    // R2 odd codewords-per-cycle rejected
    cfg_cpc = 3; cfg_ncw = 1; cfg_loop = 0; cfg_pat = 0; cfg_mask = 10'h3FF;
    set_list(0, 1, 0, 0, 2);
    pulse(1);
    chk("R2 odd rejected busy", int'(busy), 0);
    run_cws(2, 0, -1, "R2 odd");

    // R2 zero codewords-per-cycle rejected
    cfg_cpc = 0;
    pulse(1);
    chk("R2 zero rejected busy", int'(busy), 0);

    // R9 stop in mid cycle of a repeat run; repeat count 0 acts as 1 (R8)
    cfg_cpc = 4; cfg_ncw = 4; cfg_loop = 2; cfg_rep = 10; cfg_pat = 0; cfg_mask = 10'h0F0;
    set_list(6, 0, 0, 0, 1);
    n_err = 0;
    pulse(1);
    run_cws(4, -1, 2, "R9 stop");
    chk("R9 stop busy", int'(busy), 0);
    cfg_rep = 0;
    n_err = 0;
    pulse(1);
    run_cws(6, 4, -1, "R8 repeat zero");
    chk("R8 repeat zero ends", int'(busy), 0);

    // R9 stop while armed
    pulse(1);
    chk("R9 armed busy", int'(busy), 1);
    pulse(0);
    chk("R9 armed stop", int'(busy), 0);
    run_cws(1, 0, -1, "R9 armed");
    chk_counters("final");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule